// File: doc/BRIEF.md
# Handshake Word Bridge Between Clock Domains

This block carries a multi-bit word from one clock domain into another clock domain whose clock has no fixed relation to the first. The word is never passed through a synchronizer. The source side captures the offered word into a holding register and keeps it frozen. One cycle later it raises a request flag. That flag crosses to the destination through a flop chain. On its rising edge the destination samples the frozen word into an enable-gated register and raises an acknowledge flag. The acknowledge travels back through its own flop chain. The control is four-phase: request up, acknowledge up, request down, acknowledge down. Only after the full cycle may the source take another word.

Upstream logic uses a valid/ready stream. A word is accepted on a source clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls in the next cycle and stays low until the handshake for that word has finished. While `in_ready` is low, upstream may change, drop or hold `in_valid` and `in_data`, and none of it has any effect. The destination has no back-pressure. Each word is presented as a single-cycle `out_valid` strobe, and `out_data` keeps that word until the next strobe. Every signal that crosses between the domains is driven straight from a flop output.

Top module: `hsx_bridge`

## Requirements
- R1: While either reset is held, and after both resets are released with no traffic, `in_ready` is 1 and `out_valid` is 0.
- R2: After a word is accepted, `in_ready` is 0 from the next source cycle until the synchronized acknowledge for that word has gone high and then low again. It stays low for at least four source cycles.
- R3: The source holding register changes only on an accepted word. It does not change while the request or the synchronized acknowledge is high. The request never changes in the same cycle as the held word.
- R4: Every accepted word appears at `out_data` exactly once, in acceptance order, with every bit unchanged.
- R5: `out_valid` is high for exactly one destination cycle per word and is never high in two consecutive destination cycles.
- R6: Between strobes, `out_data` holds the most recently delivered word.
- R7: A word offered on `in_valid` while `in_ready` is 0, and withdrawn before `in_ready` returns, is never delivered.
- R8: The request rises only while the synchronized acknowledge is low. It falls only after the synchronized acknowledge has been seen high. The acknowledge is high whenever `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Bridge can take a word this cycle |
| in_data | input | WIDTH | Offered word |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| out_valid | output | 1 | Single-cycle strobe: a new word is on out_data |
| out_data | output | WIDTH | Last delivered word |

## Verification
The bench runs the two domains on unrelated clock periods. It sends words back to back, with idle gaps, and with patterns such as all-ones, all-zeros and alternating bits. A bridge that reopens `in_ready` too early would overwrite a held word before it was captured, and the scoreboard would see a lost or corrupted word. While `in_ready` is low the bench offers junk words and then withdraws them. A bridge that listens to `in_valid` at that time would deliver an extra word. The destination strobe is checked for width and for how often it fires, and `out_data` is checked for stability between strobes. These checks catch an edge detector that fires on a level, or a capture register that does not hold its value.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_ARM  = 2'd1,
    SRC_REQ  = 2'd2,
    SRC_DROP = 2'd3
  } src_state_e;
endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hsx_src.sv
module hsx_src
  import hsx_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             ack_s,
  output logic             req_o,
  output logic [WIDTH-1:0] hold_o
);
  src_state_e state_q, state_d;
  logic [WIDTH-1:0] hold_q;
  logic req_q;
  logic take;

  assign in_ready = (state_q == SRC_IDLE);
  assign take     = in_ready && in_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SRC_IDLE: if (in_valid) state_d = SRC_ARM;
      SRC_ARM:  state_d = SRC_REQ;
      SRC_REQ:  if (ack_s)    state_d = SRC_DROP;
      SRC_DROP: if (!ack_s)   state_d = SRC_IDLE;
      default:  state_d = SRC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRC_IDLE;
      hold_q  <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) hold_q <= in_data;
      req_q <= (state_d == SRC_REQ);
    end
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;

  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q || ack_s) |=> $stable(hold_q));
  p_req_not_with_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold_q) |-> $stable(req_q));
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);
  p_req_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !ack_s);
  p_req_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_s));
endmodule

// File: rtl/hsx_dst.sv
module hsx_dst #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_s,
  input  logic [WIDTH-1:0] hold_i,
  output logic             ack_o,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  logic req_d;
  logic ack_q;
  logic vld_q;
  logic [WIDTH-1:0] cap_q;
  logic cap_en;

  assign cap_en = req_s && !req_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d <= 1'b0;
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      cap_q <= '0;
    end else begin
      req_d <= req_s;
      ack_q <= req_s;
      vld_q <= cap_en;
      cap_q <= cap_en ? hold_i : cap_q;
    end
  end

  assign ack_o     = ack_q;
  assign out_valid = vld_q;
  assign out_data  = cap_q;

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  p_ack_with_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ack_q);
  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(cap_q));
endmodule

// File: rtl/hsx_bridge.sv
module hsx_bridge #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);
  logic req_x, req_s, ack_x, ack_s;
  logic [WIDTH-1:0] hold_x;

  hsx_src #(.WIDTH(WIDTH)) src_i (
    .clk(src_clk), .rst_n(src_rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .ack_s(ack_s), .req_o(req_x), .hold_o(hold_x)
  );

  hsx_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(req_x), .q(req_s)
  );

  hsx_dst #(.WIDTH(WIDTH)) dst_i (
    .clk(dst_clk), .rst_n(dst_rst_n),
    .req_s(req_s), .hold_i(hold_x), .ack_o(ack_x),
    .out_valid(out_valid), .out_data(out_data)
  );

  hsx_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
    .clk(src_clk), .rst_n(src_rst_n), .d(ack_x), .q(ack_s)
  );
endmodule

// File: tb/hsx_bridge_tb_top.sv
module hsx_bridge_tb_top;
  localparam int W = 32;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b0, dst_rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_data;

  int checks = 0, fails = 0, delivered = 0, sent = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_word = '0;
  logic prev_vld = 1'b0;
  bit done = 1'b0;

  always #5 src_clk = ~src_clk;
  always #8.7 dst_clk = ~dst_clk;

  hsx_bridge #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .src_clk(src_clk), .src_rst_n(src_rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers one word, waits for acceptance; junk offered while busy (R7)
  task automatic send(input logic [W-1:0] w, input bit junk);
    int low_cnt;
    @(negedge src_clk);
    while (!in_ready) begin
      if (junk) begin in_valid = 1'b1; in_data = ~w; end
      @(negedge src_clk);
    end
    in_valid = 1'b1;
    in_data  = w;
    @(posedge src_clk);
    exp_q.push_back(w);
    sent++;
    @(negedge src_clk);
    in_valid = 1'b0;
    in_data  = 32'hDEAD_0000 ^ w;
    low_cnt = 0;
    while (!in_ready) begin
      low_cnt++;
      if (junk) begin in_valid = 1'b1; in_data = w + 32'h1111; end
      @(negedge src_clk);
      in_valid = 1'b0;
    end
    // R2: busy window spans the full four-phase loop
    chk(low_cnt >= 4, "R2", low_cnt, 4);
  endtask

  // monitor: scoreboard in the destination domain
  always @(negedge dst_clk) begin
    if (dst_rst_n) begin
      if (out_valid) begin
        chk(!prev_vld, "R5", {31'b0, prev_vld}, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", out_data, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(out_data === e, "R4", out_data, e);
        end
        last_word = out_data;
        delivered++;
      end else if (delivered > 0) begin
        if (out_data !== last_word) chk(1'b0, "R6", out_data, last_word);
      end
      prev_vld = out_valid;
    end
  end

  initial begin
    #3;
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    chk(out_valid === 1'b0, "R1", out_valid, 0);
    #40 src_rst_n = 1'b1;
    #17 dst_rst_n = 1'b1;
    repeat (5) @(negedge src_clk);
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    chk(out_valid === 1'b0, "R1", out_valid, 0);

    send(32'hFFFF_FFFF, 1'b0);
    send(32'h0000_0000, 1'b0);
    send(32'hAAAA_5555, 1'b1);
    send(32'h5555_AAAA, 1'b1);
    for (int i = 0; i < 20; i++) send(32'h1357_0000 + i * 32'h0101_0103, i[0]);
    for (int i = 0; i < 8; i++) begin
      repeat (i * 3) @(negedge src_clk);
      send(32'h8000_0001 << i, 1'b1);
    end
    repeat (40) @(negedge dst_clk);
    // R4 / R7: everything delivered exactly once, nothing extra
    chk(delivered == sent, "R4", delivered, sent);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    chk(out_valid === 1'b0, "R5", out_valid, 0);
    chk(in_ready === 1'b1, "R2", in_ready, 1);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge src_clk);
      cyc++;
    end
    if (!done) chk(1'b0, "watchdog", cyc, 100000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule